// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block makes a pulse-width modulated output from an up-counting time base and a compare stage. A prescaler divides the clock by 1, 8, 64 or 256. The counter then counts from zero up to a programmed period value, restarts, and emits a one-cycle interrupt pulse at each restart. The output is high while the count is below the active duty value, so the duty can be set anywhere from fully off to fully on.

Software writes a period value, a pending duty value and, before enabling, an initial active duty value. The pending duty can be written at any time. It reaches the compare stage only at a period restart, so a duty change never cuts a pulse short. A 3-bit mode field selects the output behaviour: off, PWM, or PWM with a fault shutdown input. The shutdown input is active low. It kills the output at once and latches a flag that software must clear.

Top module: `pwm_gen_top`

## Requirements
- R1: With period value N, the counter restarts every N+1 prescaled ticks (for example, 7 gives 8 counts). The counter restarts on the tick where its count is equal to or above the period value.
- R2: `psc_sel_i` sets the prescale ratio: 0 gives 1, 1 gives 8, 2 gives 64, 3 gives 256 clock cycles per count.
- R3: A write to the pending duty register is accepted at any time. Its value moves to the active duty register (read on `duty_o`) only at a period restart.
- R4: A write to the active duty register (`pri_we_i`) takes effect only while `mode_i` is neither 3'b110 (PWM) nor 3'b111 (PWM with fault). Such a write takes priority over a restart copy. In a PWM mode the write is ignored.
- R5: In a PWM mode the output is high exactly while count < active duty. Duty 0 gives a constant low, duty above the period value gives a constant high, and duty equal to the period value gives a low for one count only.
- R6: `match_irq_o` is high for the one clock cycle that follows each restart tick, which is the cycle in which the count first reads zero.
- R7: While `tb_en_i` is low the prescaler and the counter are held at zero. After enable rises, the first restart comes (N+1)·prescale cycles later.
- R8: In any mode other than 3'b110 or 3'b111, `pwm_o` is low and the counter keeps running.
- R9: In mode 3'b111, a low `fault_ni` forces `pwm_o` low in the same cycle and sets `fault_o` at the next clock edge.
- R10: `fault_o` stays set, and keeps `pwm_o` low, until `fault_clr_i` is high while `fault_ni` is high.
- R11: After reset, the period, the duty registers and the count are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_en_i | input | 1 | Time base enable |
| psc_sel_i | input | 2 | Prescale select |
| mode_i | input | 3 | Output mode field |
| per_we_i | input | 1 | Period register write strobe |
| sec_we_i | input | 1 | Pending duty register write strobe |
| pri_we_i | input | 1 | Active duty register write strobe |
| wdata_i | input | CNT_W | Write data shared by the three strobes |
| fault_ni | input | 1 | Fault input, active low |
| fault_clr_i | input | 1 | Fault flag clear request |
| pwm_o | output | 1 | PWM output |
| match_irq_o | output | 1 | Period restart interrupt pulse |
| fault_o | output | 1 | Sticky fault flag |
| duty_o | output | CNT_W | Active duty register read value |

## Verification
The bench builds the block with CNT_W = 8 and the fault stage present. With 8 bits, a duty one above the period and the full 256 prescale ratio can both be reached within a short run. Short periods of 0, 1 and 7 make every prescale ratio and each duty edge case observable in a few hundred cycles. The fault sequence includes a clear request made while the fault is still active, which must leave the flag set.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam logic [2:0] MODE_PWM     = 3'b110;
  localparam logic [2:0] MODE_PWM_FLT = 3'b111;
  localparam int unsigned PSC_W       = 8;

  function automatic logic is_pwm(input logic [2:0] mode);
    return (mode == MODE_PWM) || (mode == MODE_PWM_FLT);
  endfunction

  // terminal prescale count: ratio minus one
  function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return PSC_W'(0);
      2'd1:    return PSC_W'(7);
      2'd2:    return PSC_W'(63);
      default: return PSC_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_gen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= psc_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_psc_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] per_q, cnt_q;

  assign match_o = tick_i && (cnt_q >= per_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      per_q <= '0;
    else if (per_we_i) per_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (cnt_q == '0));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             match_i,
  input  logic             sec_we_i,
  input  logic             pri_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] pri_o
);
  logic [CNT_W-1:0] sec_q, pri_q;
  logic             pri_wr_ok;

  assign pri_wr_ok = pri_we_i && !is_pwm(mode_i);
  assign pri_o     = pri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sec_q <= '0;
    else if (sec_we_i) sec_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pri_q <= '0;
    else if (pri_wr_ok) pri_q <= wdata_i;
    else if (match_i)   pri_q <= sec_q;
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !pri_wr_ok) |=> (pri_q == $past(sec_q)));
  p_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pwm(mode_i) && !match_i) |=> $stable(pri_q));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter bit          HAS_FAULT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             fault_ni,
  input  logic             fault_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] pri_i,
  output logic             pwm_o,
  output logic             fault_o
);
  logic blk;

  generate
    if (HAS_FAULT) begin : g_flt
      logic flt_q, flt_now;
      assign flt_now = (mode_i == MODE_PWM_FLT) && !fault_ni;
      assign blk     = flt_q || flt_now;
      assign fault_o = flt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       flt_q <= 1'b0;
        else if (flt_now)                  flt_q <= 1'b1;
        else if (fault_clr_i && fault_ni)  flt_q <= 1'b0;
      end

      p_fault_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flt_now |=> fault_o);
      p_fault_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_o && !(fault_clr_i && fault_ni)) |=> fault_o);
    end else begin : g_noflt
      assign blk     = 1'b0;
      assign fault_o = 1'b0;
    end
  endgenerate

  assign pwm_o = is_pwm(mode_i) && !blk && (cnt_i < pri_i);

  p_zero_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_i == '0) |-> !pwm_o);
  p_fault_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !pwm_o);
  p_nonpwm_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pwm(mode_i) |-> !pwm_o);
endmodule

// File: rtl/pwm_gen_top.sv
module pwm_gen_top
  import pwm_gen_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter bit          HAS_FAULT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tb_en_i,
  input  logic [1:0]       psc_sel_i,
  input  logic [2:0]       mode_i,
  input  logic             per_we_i,
  input  logic             sec_we_i,
  input  logic             pri_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             fault_ni,
  input  logic             fault_clr_i,
  output logic             pwm_o,
  output logic             match_irq_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] duty_o
);
  logic             tick, match, irq_q;
  logic [CNT_W-1:0] cnt, pri;

  pwm_prescaler u_psc (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tb_en_i),
    .sel_i (psc_sel_i), .tick_o(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(tb_en_i), .tick_i(tick),
    .per_we_i(per_we_i), .wdata_i(wdata_i), .cnt_o(cnt), .match_o(match)
  );

  pwm_duty_buf #(.CNT_W(CNT_W)) u_duty (
    .clk_i (clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .match_i(match),
    .sec_we_i(sec_we_i), .pri_we_i(pri_we_i), .wdata_i(wdata_i), .pri_o(pri)
  );

  pwm_out_stage #(.CNT_W(CNT_W), .HAS_FAULT(HAS_FAULT)) u_out (
    .clk_i (clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .fault_ni(fault_ni),
    .fault_clr_i(fault_clr_i), .cnt_i(cnt), .pri_i(pri),
    .pwm_o (pwm_o), .fault_o(fault_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= match;
  end

  assign match_irq_o = irq_q;
  assign duty_o      = pri;

  p_irq_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> (cnt == '0));
  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> $past(tb_en_i));
endmodule

// File: tb/pwm_gen_top_tb_top.sv
module pwm_gen_top_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tb_en = 1'b0;
  logic [1:0]    psc = 2'd0;
  logic [2:0]    mode = 3'd0;
  logic          per_we = 1'b0, sec_we = 1'b0, pri_we = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic          flt_n = 1'b1, flt_clr = 1'b0;
  logic          pwm, irq, flt;
  logic [CW-1:0] duty;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  string cur_req = "R11";

  // reference model state
  int m_psc, m_tmr, m_per, m_sec, m_pri;
  bit m_irq, m_flt;

  pwm_gen_top #(.CNT_W(CW), .HAS_FAULT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tb_en_i(tb_en), .psc_sel_i(psc),
    .mode_i(mode), .per_we_i(per_we), .sec_we_i(sec_we), .pri_we_i(pri_we),
    .wdata_i(wdata), .fault_ni(flt_n), .fault_clr_i(flt_clr),
    .pwm_o(pwm), .match_irq_o(irq), .fault_o(flt), .duty_o(duty)
  );

  always #10 clk = ~clk;

  function automatic bit m_is_pwm();
    return (mode == 3'b110) || (mode == 3'b111);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psc = 0; m_tmr = 0; m_per = 0; m_sec = 0; m_pri = 0;
      m_irq = 0; m_flt = 0;
    end else begin
      int lim, old_sec;
      bit hit;
      lim = (psc == 0) ? 0 : (psc == 1) ? 7 : (psc == 2) ? 63 : 255;
      hit = 0;
      old_sec = m_sec;
      if (!tb_en) begin
        m_psc = 0; m_tmr = 0;
      end else if (m_psc >= lim) begin
        m_psc = 0;
        if (m_tmr >= m_per) begin m_tmr = 0; hit = 1; end
        else m_tmr = m_tmr + 1;
      end else m_psc = m_psc + 1;
      if (per_we) m_per = int'(wdata);
      if (sec_we) m_sec = int'(wdata);
      if (pri_we && !m_is_pwm()) m_pri = int'(wdata);
      else if (hit) m_pri = old_sec;
      m_irq = hit;
      if (mode == 3'b111 && !flt_n) m_flt = 1;
      else if (flt_clr && flt_n) m_flt = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_pwm;
      e_pwm = m_is_pwm() && !m_flt && !(mode == 3'b111 && !flt_n) && (m_tmr < m_pri);
      chk(int'(pwm), int'(e_pwm), cur_req, "pwm_o");
      chk(int'(irq), int'(m_irq), cur_req, "match_irq_o");
      chk(int'(flt), int'(m_flt), cur_req, "fault_o");
      chk(int'(duty), m_pri, cur_req, "duty_o");
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int sel, input int val);
    wdata = CW'(val);
    per_we = (sel == 0); sec_we = (sel == 1); pri_we = (sel == 2);
    step();
    per_we = 0; sec_we = 0; pri_we = 0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq);
  endtask

  task automatic spacing(output int n);
    wait_irq();
    n = 0;
    do begin @(negedge clk); n++; end while (!irq);
  endtask

  task automatic high_cnt(input int len, output int hi);
    wait_irq();
    hi = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(int'(pwm), 0, "R11", "pwm_o in reset");
    chk(int'(irq), 0, "R11", "irq in reset");
    chk(int'(flt), 0, "R11", "fault_o in reset");
    chk(int'(duty), 0, "R11", "duty_o in reset");
    step(); rst_n = 1'b1; step();

    cur_req = "R4";
    wr(0, 7); wr(1, 3); wr(2, 3);
    chk(int'(duty), 3, "R4", "duty written while not PWM");
    mode = 3'b110; tb_en = 1'b1; step();

    cur_req = "R1";
    spacing(n); chk(n, 8, "R1", "period 7 spacing");
    cur_req = "R5";
    high_cnt(8, n); chk(n, 3, "R5", "duty 3 high counts");

    cur_req = "R3";
    wait_irq(); wr(1, 5);
    @(negedge clk); chk(int'(duty), 3, "R3", "duty before restart");
    high_cnt(8, n); chk(n, 5, "R3", "new duty after restart");
    chk(int'(duty), 5, "R3", "duty_o after restart");

    cur_req = "R5";
    wr(1, 0); wait_irq(); high_cnt(8, n); chk(n, 0, "R5", "duty 0 always low");
    wr(1, 8); wait_irq(); high_cnt(8, n); chk(n, 8, "R5", "duty above period always high");
    wr(1, 7); wait_irq(); high_cnt(8, n); chk(n, 7, "R5", "duty equal period low once");

    cur_req = "R4";
    wait_irq(); wr(2, 2);
    @(negedge clk); chk(int'(duty), 7, "R4", "write ignored in PWM mode");

    cur_req = "R2";
    psc = 2'd1; step();
    spacing(n); spacing(n); chk(n, 64, "R2", "ratio 8 spacing");
    wr(0, 1); psc = 2'd2; step();
    spacing(n); spacing(n); chk(n, 128, "R2", "ratio 64 spacing");
    wr(0, 0); psc = 2'd3; step();
    spacing(n); spacing(n); chk(n, 256, "R2", "ratio 256 spacing");
    psc = 2'd0; wr(0, 7); wr(1, 4);
    spacing(n); spacing(n); chk(n, 8, "R1", "period restored");

    cur_req = "R6";
    wait_irq(); @(negedge clk); chk(int'(irq), 0, "R6", "pulse one cycle wide");

    cur_req = "R8";
    mode = 3'b000; step();
    high_cnt(8, n); chk(n, 0, "R8", "non-PWM output low");
    spacing(n); chk(n, 8, "R8", "counter keeps running");

    cur_req = "R7";
    mode = 3'b110; tb_en = 1'b0;
    repeat (5) step();
    @(negedge clk); chk(int'(pwm), 1, "R7", "held at zero count is below duty");
    tb_en = 1'b1; step();
    n = 0;
    do begin @(negedge clk); n++; end while (!irq);
    chk(n, 8, "R7", "first restart after enable");

    cur_req = "R9";
    mode = 3'b111; wait_irq(); step();
    flt_n = 1'b0; #1;
    chk(int'(pwm), 0, "R9", "output cut immediately");
    step();
    @(negedge clk);
    chk(int'(flt), 1, "R9", "fault flag set");
    chk(int'(pwm), 0, "R9", "output low in fault");

    cur_req = "R10";
    flt_n = 1'b1; step();
    high_cnt(8, n); chk(n, 0, "R10", "output off while flag set");
    flt_n = 1'b0; flt_clr = 1'b1; step();
    flt_n = 1'b1; flt_clr = 1'b0; step();
    @(negedge clk); chk(int'(flt), 1, "R10", "clear ignored while fault low");
    flt_clr = 1'b1; step(); flt_clr = 1'b0;
    @(negedge clk); chk(int'(flt), 0, "R10", "flag cleared");
    high_cnt(8, n); chk(n, 4, "R10", "output resumes");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule